// File: doc/BRIEF.md
# Interrupt and Error Status Latch

This block gathers single-cycle event pulses from around a peripheral controller and holds them in two status bytes. The first is an interrupt code, which drives an active-high interrupt line. The second is an error code. Its sources are a keypad event, changes on two general-purpose input pins, and four error conditions. The pin changes only count for pins whose interrupt enable is set.

A host reaches the block through a one-byte command port. Opcode 0xD0 returns the interrupt code and clears it, which drops the interrupt line. Opcode 0xF0 returns the error code and clears it. Other decoders elsewhere in the chip may claim further opcodes through a claim input. Any opcode that nobody claims is itself recorded as an error. An event that arrives in the same cycle as the clear that would erase it is kept.

Top module: `evt_status_unit`

## Requirements
- R1: After reset both codes are zero, `irq` is low and `rspValid` is low.
- R2: A `keyEvent` pulse sets interrupt bit 0, which stays set until a 0xD0 command clears it.
- R3: With both pins enabled (`gpIrqEn` = 2'b11), a rising or a falling change on pin n sets only interrupt bit n+1 (pin 0 sets bit 1, pin 1 sets bit 2).
- R4: With exactly one pin enabled, a change on that pin sets both interrupt bits 1 and 2.
- R5: A change on a pin whose enable is low leaves the interrupt code unchanged.
- R6: Error pulses set sticky error bits: `errCmdOvr` sets bit 0, an unknown opcode sets bit 1, `errKeyOvf` sets bit 2 and `errFifoOvf` sets bit 6. A 0xF0 command returns the error code and clears it; the other bits read as zero.
- R7: Any error pulse also sets interrupt bit 3. A 0xF0 command does not clear bit 3; only 0xD0 does.
- R8: Command timing. One cycle after a 0xD0 or 0xF0 command, `rspValid` is high for one cycle and `rspData` holds the code as it was before the clear. Interrupt code bits 7..4 read as zero.
- R9: An event arriving in the same cycle as the clear of its code is not in that response. It remains set afterwards.
- R10: `irq` is registered, active high, and high exactly while the interrupt code is non-zero; it falls in the cycle after a 0xD0 clear.
- R11: An opcode other than 0xD0 and 0xF0 sets error bit 1, unless `extClaim` is high with it. Such an opcode gives no response.
- R12: Pin levels present during reset do not count as changes when reset ends.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| keyEvent | input | 1 | Keypad event pulse |
| gpIn | input | 2 | General-purpose pin levels (synchronous) |
| gpIrqEn | input | 2 | Per-pin interrupt enable |
| errFifoOvf | input | 1 | FIFO overflow pulse |
| errKeyOvf | input | 1 | Key-event overflow pulse |
| errCmdOvr | input | 1 | Command overrun pulse |
| cmdValid | input | 1 | Opcode present this cycle |
| cmdOpcode | input | 8 | Command opcode |
| extClaim | input | 1 | Another decoder owns this opcode |
| rspValid | output | 1 | Response byte valid |
| rspData | output | 8 | Response byte |
| irq | output | 1 | Interrupt request, active high |

## Verification
The bench drives a key event and an error pulse in the same cycle as the read that clears their code. If set did not win over clear, the event would be lost, or it would show up early in the snapshot. It walks through every enable combination on the two pins. A design that failed to fan out to both bits would show one bit when only one pin is enabled. A design that ignored the enables would report changes on disabled pins. The bench also checks that an error read leaves interrupt bit 3 and the interrupt line alone. It checks that claimed opcodes are not flagged as unknown. It checks that pins held high through reset produce no interrupt when reset ends.

// File: rtl/evt_status_pkg.sv
package evt_status_pkg;
  localparam int CODE_W = 8;
  localparam int GP_N   = 2;

  localparam int INT_KEY_BIT  = 0;
  localparam int INT_GP0_BIT  = 1;
  localparam int INT_GP1_BIT  = 2;
  localparam int INT_ERR_BIT  = 3;

  localparam int ERR_CMDOVR_BIT = 0;
  localparam int ERR_UNKCMD_BIT = 1;
  localparam int ERR_KEYOVF_BIT = 2;
  localparam int ERR_FIFOVF_BIT = 6;

  typedef logic [CODE_W-1:0] code_t;

  typedef struct packed {
    logic rdInt;
    logic rdErr;
    logic unkCmd;
  } ctrlStrb_t;
endpackage

// File: rtl/evt_edge_det.sv
module evt_edge_det (
  input  logic clk,
  input  logic rstN,
  input  logic pinIn,
  output logic edgeOut
);
  logic pinPrev;
  logic primed;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pinPrev <= 1'b0;
      primed  <= 1'b0;
    end else begin
      pinPrev <= pinIn;
      primed  <= 1'b1;
    end
  end

  assign edgeOut = primed & (pinIn ^ pinPrev);

  // R12
  no_edge_unprimed_chk: assert property (@(posedge clk) disable iff (!rstN)
    !primed |-> !edgeOut);
endmodule

// File: rtl/evt_status_ctrl.sv
module evt_status_ctrl
  import evt_status_pkg::*;
#(
  parameter logic [7:0] OP_RD_INT = 8'hD0,
  parameter logic [7:0] OP_RD_ERR = 8'hF0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       cmdValid,
  input  logic [7:0] cmdOpcode,
  input  logic       extClaim,
  output ctrlStrb_t  strb,
  output logic       rspValid
);
  logic isRdInt;
  logic isRdErr;

  always_comb begin
    isRdInt     = cmdOpcode == OP_RD_INT;
    isRdErr     = cmdOpcode == OP_RD_ERR;
    strb.rdInt  = cmdValid & isRdInt;
    strb.rdErr  = cmdValid & isRdErr;
    strb.unkCmd = cmdValid & !isRdInt & !isRdErr & !extClaim;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) rspValid <= 1'b0;
    else       rspValid <= strb.rdInt | strb.rdErr;
  end

  // R11
  strobe_excl_chk: assert property (@(posedge clk) disable iff (!rstN)
    $onehot0({strb.rdInt, strb.rdErr, strb.unkCmd}));

  // R8
  rsp_pulse_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && (cmdOpcode == OP_RD_INT || cmdOpcode == OP_RD_ERR)) |=> rspValid);

  // R11
  unk_no_rsp_chk: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && cmdOpcode != OP_RD_INT && cmdOpcode != OP_RD_ERR) |=> !rspValid);
endmodule

// File: rtl/evt_status_dp.sv
module evt_status_dp
  import evt_status_pkg::*;
(
  input  logic            clk,
  input  logic            rstN,
  input  ctrlStrb_t       strb,
  input  logic            keyEvent,
  input  logic [GP_N-1:0] gpIn,
  input  logic [GP_N-1:0] gpIrqEn,
  input  logic            errFifoOvf,
  input  logic            errKeyOvf,
  input  logic            errCmdOvr,
  output code_t           rspData,
  output logic            irq
);
  logic [GP_N-1:0] pinEdge;
  logic [GP_N-1:0] qualEdge;
  logic [GP_N-1:0] gpSet;
  code_t           intCode, intNext, intSet;
  code_t           errCode, errNext, errSet;

  for (genvar g = 0; g < GP_N; g++) begin : g_edge
    evt_edge_det edge_i (
      .clk    (clk),
      .rstN   (rstN),
      .pinIn  (gpIn[g]),
      .edgeOut(pinEdge[g])
    );
  end

  always_comb begin
    qualEdge = pinEdge & gpIrqEn;
    if (&gpIrqEn) gpSet = qualEdge;
    else          gpSet = {GP_N{|qualEdge}};

    errSet                 = '0;
    errSet[ERR_CMDOVR_BIT] = errCmdOvr;
    errSet[ERR_UNKCMD_BIT] = strb.unkCmd;
    errSet[ERR_KEYOVF_BIT] = errKeyOvf;
    errSet[ERR_FIFOVF_BIT] = errFifoOvf;

    intSet              = '0;
    intSet[INT_KEY_BIT] = keyEvent;
    intSet[INT_GP0_BIT] = gpSet[0];
    intSet[INT_GP1_BIT] = gpSet[1];
    intSet[INT_ERR_BIT] = |errSet;

    intNext = (strb.rdInt ? '0 : intCode) | intSet;
    errNext = (strb.rdErr ? '0 : errCode) | errSet;
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      intCode <= '0;
      errCode <= '0;
      rspData <= '0;
      irq     <= 1'b0;
    end else begin
      intCode <= intNext;
      errCode <= errNext;
      irq     <= |intNext;
      if (strb.rdInt)      rspData <= intCode;
      else if (strb.rdErr) rspData <= errCode;
    end
  end

  // R10
  irq_tracks_code_chk: assert property (@(posedge clk) disable iff (!rstN)
    irq == (intCode != '0));

  // R2
  key_sets_chk: assert property (@(posedge clk) disable iff (!rstN)
    keyEvent |=> intCode[INT_KEY_BIT]);

  // R2
  key_sticky_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intCode[INT_KEY_BIT] && !strb.rdInt) |=> intCode[INT_KEY_BIT]);

  // R7
  err_summary_chk: assert property (@(posedge clk) disable iff (!rstN)
    (errFifoOvf || errKeyOvf || errCmdOvr || strb.unkCmd) |=> intCode[INT_ERR_BIT]);

  // R7
  err_read_keeps_sum_chk: assert property (@(posedge clk) disable iff (!rstN)
    (intCode[INT_ERR_BIT] && strb.rdErr) |=> intCode[INT_ERR_BIT]);

  // R6
  err_clear_chk: assert property (@(posedge clk) disable iff (!rstN)
    (strb.rdErr && !errFifoOvf && !errKeyOvf && !errCmdOvr) |=> errCode == '0);

  // R8
  int_upper_zero_chk: assert property (@(posedge clk) disable iff (!rstN)
    intCode[CODE_W-1:INT_ERR_BIT+1] == '0);
endmodule

// File: rtl/evt_status_unit.sv
module evt_status_unit
  import evt_status_pkg::*;
#(
  parameter logic [7:0] OP_RD_INT = 8'hD0,
  parameter logic [7:0] OP_RD_ERR = 8'hF0
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       keyEvent,
  input  logic [1:0] gpIn,
  input  logic [1:0] gpIrqEn,
  input  logic       errFifoOvf,
  input  logic       errKeyOvf,
  input  logic       errCmdOvr,
  input  logic       cmdValid,
  input  logic [7:0] cmdOpcode,
  input  logic       extClaim,
  output logic       rspValid,
  output logic [7:0] rspData,
  output logic       irq
);
  ctrlStrb_t strb;

  evt_status_ctrl #(
    .OP_RD_INT(OP_RD_INT),
    .OP_RD_ERR(OP_RD_ERR)
  ) ctrl_i (
    .clk      (clk),
    .rstN     (rstN),
    .cmdValid (cmdValid),
    .cmdOpcode(cmdOpcode),
    .extClaim (extClaim),
    .strb     (strb),
    .rspValid (rspValid)
  );

  evt_status_dp dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strb      (strb),
    .keyEvent  (keyEvent),
    .gpIn      (gpIn),
    .gpIrqEn   (gpIrqEn),
    .errFifoOvf(errFifoOvf),
    .errKeyOvf (errKeyOvf),
    .errCmdOvr (errCmdOvr),
    .rspData   (rspData),
    .irq       (irq)
  );
endmodule

// File: tb/evt_status_unit_tb_top.sv
module evt_status_unit_tb_top;
  logic       clk = 1'b0;
  logic       rstN = 1'b0;
  logic       keyEvent = 1'b0;
  logic [1:0] gpIn = 2'b11;
  logic [1:0] gpIrqEn = 2'b11;
  logic       errFifoOvf = 1'b0;
  logic       errKeyOvf = 1'b0;
  logic       errCmdOvr = 1'b0;
  logic       cmdValid = 1'b0;
  logic [7:0] cmdOpcode = 8'h00;
  logic       extClaim = 1'b0;
  logic       rspValid;
  logic [7:0] rspData;
  logic       irq;

  int checks = 0;
  int errors = 0;

  always #2 clk = ~clk;

  evt_status_unit dut_i (
    .clk(clk), .rstN(rstN), .keyEvent(keyEvent), .gpIn(gpIn), .gpIrqEn(gpIrqEn),
    .errFifoOvf(errFifoOvf), .errKeyOvf(errKeyOvf), .errCmdOvr(errCmdOvr),
    .cmdValid(cmdValid), .cmdOpcode(cmdOpcode), .extClaim(extClaim),
    .rspValid(rspValid), .rspData(rspData), .irq(irq)
  );

  task automatic check(input bit ok, input string tag, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Called at a negedge; returns at the next negedge with the response.
  task automatic sendCmd(input logic [7:0] op, input logic ext,
                         output logic [7:0] data, output logic valid);
    cmdValid  = 1'b1;
    cmdOpcode = op;
    extClaim  = ext;
    @(negedge clk);
    valid    = rspValid;
    data     = rspData;
    cmdValid = 1'b0;
    extClaim = 1'b0;
  endtask

  task automatic expectRead(input logic [7:0] op, input logic [7:0] exp, input string tag);
    logic [7:0] d;
    logic v;
    sendCmd(op, 1'b0, d, v);
    check(v === 1'b1, {tag, " rspValid"}, {7'd0, v}, 8'h01);
    check(d === exp, tag, d, exp);
    @(negedge clk);
  endtask

  task automatic tReset;
    check(irq === 1'b0, "R1 irq low", {7'd0, irq}, 8'h00);
    check(rspValid === 1'b0, "R1 rspValid low", {7'd0, rspValid}, 8'h00);
    // pins held high through reset must not register (R12)
    expectRead(8'hD0, 8'h00, "R12 no edge from reset levels");
    expectRead(8'hF0, 8'h00, "R1 error code zero");
    gpIn = 2'b00;  // falling on both pins, both enabled (R3)
    @(negedge clk);
    expectRead(8'hD0, 8'h06, "R3 falling on both pins");
  endtask

  task automatic tKeypad;
    keyEvent = 1'b1;
    @(negedge clk);
    keyEvent = 1'b0;
    check(irq === 1'b1, "R10 irq rises with code", {7'd0, irq}, 8'h01);
    repeat (3) @(negedge clk);
    check(irq === 1'b1, "R2 sticky irq", {7'd0, irq}, 8'h01);
    expectRead(8'hD0, 8'h01, "R2 keypad bit");
    check(irq === 1'b0, "R10 irq falls after read", {7'd0, irq}, 8'h00);
    expectRead(8'hD0, 8'h00, "R8 cleared by read");
  endtask

  task automatic tGpBoth;
    gpIrqEn = 2'b11;
    gpIn = 2'b10;
    @(negedge clk);
    expectRead(8'hD0, 8'h04, "R3 pin1 rising only bit2");
    gpIn = 2'b11;
    @(negedge clk);
    expectRead(8'hD0, 8'h02, "R3 pin0 rising only bit1");
    gpIn = 2'b10;
    @(negedge clk);
    expectRead(8'hD0, 8'h02, "R3 pin0 falling only bit1");
  endtask

  task automatic tGpOne;
    gpIrqEn = 2'b01;
    gpIn = 2'b11;
    @(negedge clk);
    expectRead(8'hD0, 8'h06, "R4 pin0 alone sets both");
    gpIn = 2'b01;
    @(negedge clk);
    expectRead(8'hD0, 8'h00, "R5 disabled pin1 ignored");
    check(irq === 1'b0, "R5 irq stays low", {7'd0, irq}, 8'h00);
    gpIrqEn = 2'b10;
    gpIn = 2'b11;
    @(negedge clk);
    expectRead(8'hD0, 8'h06, "R4 pin1 alone sets both");
    gpIn = 2'b10;
    @(negedge clk);
    expectRead(8'hD0, 8'h00, "R5 disabled pin0 ignored");
    gpIrqEn = 2'b00;
    gpIn = 2'b01;
    @(negedge clk);
    expectRead(8'hD0, 8'h00, "R5 no pin enabled");
    gpIrqEn = 2'b11;
  endtask

  task automatic tErrors;
    errFifoOvf = 1'b1;
    errKeyOvf  = 1'b1;
    errCmdOvr  = 1'b1;
    @(negedge clk);
    errFifoOvf = 1'b0;
    errKeyOvf  = 1'b0;
    errCmdOvr  = 1'b0;
    repeat (2) @(negedge clk);
    expectRead(8'hF0, 8'h45, "R6 error bits 0,2,6");
    expectRead(8'hF0, 8'h00, "R6 error cleared by read");
    check(irq === 1'b1, "R7 error read keeps irq", {7'd0, irq}, 8'h01);
    expectRead(8'hD0, 8'h08, "R7 summary bit survives error read");
    check(irq === 1'b0, "R10 irq low after clear", {7'd0, irq}, 8'h00);
    errCmdOvr = 1'b1;
    @(negedge clk);
    errCmdOvr = 1'b0;
    expectRead(8'hF0, 8'h01, "R6 command overrun alone");
    expectRead(8'hD0, 8'h08, "R7 summary from single error");
  endtask

  task automatic tSameCycle;
    logic [7:0] d;
    logic v;
    keyEvent = 1'b1;
    sendCmd(8'hD0, 1'b0, d, v);
    keyEvent = 1'b0;
    check(d === 8'h00, "R9 snapshot excludes same-cycle event", d, 8'h00);
    check(irq === 1'b1, "R9 irq held by kept event", {7'd0, irq}, 8'h01);
    @(negedge clk);
    expectRead(8'hD0, 8'h01, "R9 key event kept");
    errKeyOvf = 1'b1;
    sendCmd(8'hF0, 1'b0, d, v);
    errKeyOvf = 1'b0;
    check(d === 8'h00, "R9 error snapshot", d, 8'h00);
    @(negedge clk);
    expectRead(8'hF0, 8'h04, "R9 key overflow kept");
    expectRead(8'hD0, 8'h08, "R9 summary kept");
  endtask

  task automatic tUnknown;
    logic [7:0] d;
    logic v;
    sendCmd(8'h33, 1'b0, d, v);
    check(v === 1'b0, "R11 no response to unknown", {7'd0, v}, 8'h00);
    @(negedge clk);
    expectRead(8'hF0, 8'h02, "R11 unknown flag");
    expectRead(8'hD0, 8'h08, "R7 unknown sets summary");
    sendCmd(8'h44, 1'b1, d, v);
    check(v === 1'b0, "R11 claimed opcode no response", {7'd0, v}, 8'h00);
    @(negedge clk);
    expectRead(8'hF0, 8'h00, "R11 claimed opcode not flagged");
    expectRead(8'hD0, 8'h00, "R11 claimed opcode no summary");
    check(irq === 1'b0, "R10 idle irq low", {7'd0, irq}, 8'h00);
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);
    tReset;
    tKeypad;
    tGpBoth;
    tGpOne;
    tErrors;
    tSameCycle;
    tUnknown;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end

  initial begin
    repeat (20000) @(posedge clk);
    errors++;
    checks++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule